// File: doc/BRIEF.md
# Vertical Correction Linear Interpolator

This block turns a coarse grid of 6-bit correction samples into one value per column for every display line. The grid has 16 columns and up to 13 rows. The current line falls between two adjacent grid rows. The block reads both rows from an external synchronous memory and blends them linearly by the line's offset inside the row interval. It then hands the blended value to a horizontal sequencer. That sequencer asks for one column at a time and receives the result two cycles later.

Line timing is taken from two inputs. A vertical start pulse, whose polarity is programmable, restarts the walk through the grid. A one-cycle line tick advances it. Software configures the number of lines between grid rows and supplies a truncated reciprocal of that spacing, so no divider is needed. Software also sets a count of lines during which the first row is held unchanged, a step count that limits how often the blend weight is refreshed, and the first and last grid rows in use. The walk through the rows can be mirrored to support a panel scanned bottom-up.

Top module: `vcorr_interp`

## Requirements
- R1: For a used row pair with left value f0 and right value f1, a used offset a and a reciprocal code r, the output is f0 + floor((d·a·r + 2048) / 4096), where d = f1 − f0 is signed and r weights bit 6 as 2^-6 down to bit 0 as 2^-12.
- R2: When the used offset is 0, the output equals the first row's stored value exactly.
- R3: The front edge of the active vertical start level restarts the walk at the first row with offset 0. With `cfg_vs_pol`=1 this edge is a rising edge of `vs_in`; with `cfg_vs_pol`=0 it is a falling edge.
- R4: For the first `cfg_hold` line ticks after the restart, the walk does not advance, so the first row is presented unchanged.
- R5: After the hold, the used row and offset are refreshed only on every N-th advancing tick, where N is `cfg_step` and a value of 0 is treated as 1. Between refreshes the previous used values stay in place.
- R6: Each advancing tick increments the offset. When the offset equals spacing−1, the tick instead moves to the next row with offset 0. A `cfg_spacing` of 0 means 64 lines.
- R7: When the walk reaches the last row, that row's value is output with offset 0 and is held until the next restart. The used values are refreshed on the tick that reaches the last row, whatever N is.
- R8: With `cfg_dir_norm`=0, logical row m is read from physical row first+last−m. With `cfg_dir_norm`=1, it is read from physical row m.
- R9: `rd_addr_a` is phys(row)·16 + column and `rd_addr_b` is phys(next row)·16 + column. The next row is the row itself once the last row is reached.
- R10: The output is saturated to the range 0..63.
- R11: A request with `col_valid` high in cycle t yields `out_valid` high in cycle t+2, with `out_col` equal to the requested column.
- R12: After reset, `out_valid` and `out_value` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vs_in | input | 1 | Vertical start pulse |
| line_tick | input | 1 | One-cycle pulse per display line |
| cfg_spacing | input | 6 | Lines between grid rows, 0 means 64 |
| cfg_recip | input | 7 | Truncated reciprocal of the spacing |
| cfg_hold | input | 4 | Lines the first row is held |
| cfg_step | input | 5 | Refresh interval in lines, 0 treated as 1 |
| cfg_row_first | input | 4 | First grid row in use |
| cfg_row_last | input | 4 | Last grid row in use |
| cfg_vs_pol | input | 1 | 1: start is active high, 0: active low |
| cfg_dir_norm | input | 1 | 1: normal row order, 0: mirrored |
| col_valid | input | 1 | Column request strobe |
| col_idx | input | 4 | Requested column |
| rd_addr_a | output | 8 | Grid address of the current row |
| rd_addr_b | output | 8 | Grid address of the following row |
| rd_data_a | input | 6 | Memory data for rd_addr_a, one cycle after the address |
| rd_data_b | input | 6 | Memory data for rd_addr_b, one cycle after the address |
| out_valid | output | 1 | Result strobe |
| out_value | output | 6 | Interpolated correction value |
| out_col | output | 4 | Column of the result |

## Verification
A wrong row or offset counter shows up as a wrong grid address in the same cycle a column is requested. It also shows up as a wrong value two cycles later, and the error stays until the next vertical start. For this reason every line of each configured frame is checked on several columns, including the lines after the last row. A faulty rounding, sign or clamp stage changes `out_value` only for particular differences and offsets. To expose these, the memory holds rows with extreme neighbouring values, and an oversized reciprocal is used to drive the blend past both rails.

// File: rtl/vci_pkg.sv
package vci_pkg;
  localparam int COL_W_D  = 4;
  localparam int ROW_W_D  = 4;
  localparam int DW_D     = 6;
  localparam int SPC_W_D  = 6;
  localparam int FRAC_W_D = 7;
  localparam int HOLD_W_D = 4;
  localparam int STEP_W_D = 5;

  typedef enum logic {DIR_MIRROR = 1'b0, DIR_NORMAL = 1'b1} dir_e;
endpackage

// File: rtl/vci_line_track.sv
module vci_line_track
  import vci_pkg::*;
#(
  parameter int ROW_W  = ROW_W_D,
  parameter int SPC_W  = SPC_W_D,
  parameter int HOLD_W = HOLD_W_D,
  parameter int STEP_W = STEP_W_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vs_in,
  input  logic              vs_pol,
  input  logic              line_tick,
  input  logic [SPC_W-1:0]  spacing,
  input  logic [HOLD_W-1:0] hold,
  input  logic [STEP_W-1:0] step,
  input  logic [ROW_W-1:0]  row_first,
  input  logic [ROW_W-1:0]  row_last,
  output logic [ROW_W-1:0]  row_u,
  output logic [SPC_W-1:0]  off_u
);
  logic              vs_act, vs_q, vs_edge;
  logic [ROW_W-1:0]  row_l, nrow;
  logic [SPC_W-1:0]  off_l, noff, spc_m1;
  logic [HOLD_W-1:0] hold_left;
  logic [STEP_W-1:0] step_cnt, step_m1;
  logic              at_end, wrap;

  assign vs_act  = vs_pol ? vs_in : ~vs_in;
  assign vs_edge = vs_act & ~vs_q;
  assign spc_m1  = spacing - SPC_W'(1);
  assign step_m1 = (step == '0) ? '0 : step - STEP_W'(1);
  assign at_end  = (row_l >= row_last);
  assign wrap    = (step_cnt >= step_m1);

  always_comb begin
    if (off_l == spc_m1) begin
      nrow = row_l + ROW_W'(1);
      noff = '0;
    end else begin
      nrow = row_l;
      noff = off_l + SPC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q <= 1'b1;
    end else begin
      vs_q <= vs_act;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_l     <= '0;
      off_l     <= '0;
      row_u     <= '0;
      off_u     <= '0;
      hold_left <= '0;
      step_cnt  <= '0;
    end else if (vs_edge) begin
      row_l     <= row_first;
      off_l     <= '0;
      row_u     <= row_first;
      off_u     <= '0;
      hold_left <= hold;
      step_cnt  <= '0;
    end else if (line_tick) begin
      if (hold_left != '0) begin
        hold_left <= hold_left - HOLD_W'(1);
      end else if (!at_end) begin
        row_l <= nrow;
        off_l <= noff;
        if (wrap) step_cnt <= '0;
        else      step_cnt <= step_cnt + STEP_W'(1);
        if (wrap || (nrow >= row_last)) begin
          row_u <= nrow;
          off_u <= noff;
        end
      end
    end
  end

  // R3: a start edge lands the used state on the first row, offset zero
  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(vs_edge)) |-> (row_u == $past(row_first) && off_u == '0));

  // R4: ticks spent in the hold window leave the used state alone
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!vs_edge && line_tick && hold_left != '0) |=> ($stable(row_u) && $stable(off_u)));

  // R5: without a tick or a restart the used state never moves
  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!vs_edge && !line_tick) |=> ($stable(row_u) && $stable(off_u)));

  // R7: once at the last row the walk is frozen
  p_end_r7: assert property (@(posedge clk) disable iff (rst)
    (!vs_edge && line_tick && at_end) |=> ($stable(row_l) && $stable(off_u) && $stable(row_u)));
endmodule

// File: rtl/vci_row_map.sv
module vci_row_map
  import vci_pkg::*;
#(
  parameter int ROW_W = ROW_W_D,
  parameter int COL_W = COL_W_D
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ROW_W-1:0]       row_u,
  input  logic [ROW_W-1:0]       row_first,
  input  logic [ROW_W-1:0]       row_last,
  input  logic                   dir_norm,
  input  logic [COL_W-1:0]       col,
  output logic [ROW_W+COL_W-1:0] addr_a,
  output logic [ROW_W+COL_W-1:0] addr_b
);
  localparam int AW = ROW_W + COL_W;

  logic [ROW_W-1:0] logical [2];
  logic [AW-1:0]    addr    [2];

  assign logical[0] = row_u;
  assign logical[1] = (row_u >= row_last) ? row_u : row_u + ROW_W'(1);

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_port
      logic [ROW_W-1:0] phys;
      always_comb begin
        if (dir_e'(dir_norm) == DIR_NORMAL) phys = logical[gi];
        else                                phys = row_first + row_last - logical[gi];
      end
      assign addr[gi] = {phys, col};
    end
  endgenerate

  assign addr_a = addr[0];
  assign addr_b = addr[1];

  // R8: inside the active range, both reads stay inside it in either direction
  p_in_range_r8: assert property (@(posedge clk) disable iff (rst)
    (row_first <= row_last && row_u >= row_first && row_u <= row_last) |->
      (addr_a[AW-1:COL_W] >= row_first && addr_a[AW-1:COL_W] <= row_last &&
       addr_b[AW-1:COL_W] >= row_first && addr_b[AW-1:COL_W] <= row_last));
endmodule

// File: rtl/vci_lerp.sv
module vci_lerp
  import vci_pkg::*;
#(
  parameter int DW     = DW_D,
  parameter int COL_W  = COL_W_D,
  parameter int SPC_W  = SPC_W_D,
  parameter int FRAC_W = FRAC_W_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SPC_W-1:0]  off_u,
  input  logic [FRAC_W-1:0] recip,
  input  logic              req_v,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DW-1:0]     da,
  input  logic [DW-1:0]     db,
  output logic              out_valid,
  output logic [DW-1:0]     out_value,
  output logic [COL_W-1:0]  out_col
);
  localparam int KW    = SPC_W + FRAC_W;
  localparam int SHIFT = SPC_W + FRAC_W - 1;
  localparam int PW    = DW + KW + 3;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (SHIFT - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((1 << DW) - 1);

  logic [KW-1:0]          k;
  logic                   v_q;
  logic [COL_W-1:0]       col_q;
  logic signed [DW:0]     diff;
  logic signed [PW-1:0]   diff_x, k_x, prod, rnd, sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      k     <= '0;
      v_q   <= 1'b0;
      col_q <= '0;
    end else begin
      k     <= KW'(off_u) * KW'(recip);
      v_q   <= req_v;
      col_q <= req_col;
    end
  end

  always_comb begin
    diff   = $signed({1'b0, db}) - $signed({1'b0, da});
    diff_x = PW'(diff);
    k_x    = $signed(PW'(k));
    prod   = diff_x * k_x;
    rnd    = (prod + HALF) >>> SHIFT;
    sum    = rnd + $signed(PW'(da));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_value <= '0;
      out_col   <= '0;
    end else begin
      out_valid <= v_q;
      out_col   <= col_q;
      if (sum < 0)         out_value <= '0;
      else if (sum > MAXV) out_value <= MAXV[DW-1:0];
      else                 out_value <= sum[DW-1:0];
    end
  end

  // R2: a zero weight passes the first row through untouched
  p_exact_r2: assert property (@(posedge clk) disable iff (rst)
    (v_q && k == '0) |=> (out_value == $past(da)));

  // R10: a blend beyond the top rail reports the top code
  p_sat_hi_r10: assert property (@(posedge clk) disable iff (rst)
    (v_q && sum > MAXV) |=> (out_value == MAXV[DW-1:0]));
endmodule

// File: rtl/vcorr_interp.sv
module vcorr_interp
  import vci_pkg::*;
#(
  parameter int COL_W  = COL_W_D,
  parameter int ROW_W  = ROW_W_D,
  parameter int DW     = DW_D,
  parameter int SPC_W  = SPC_W_D,
  parameter int FRAC_W = FRAC_W_D,
  parameter int HOLD_W = HOLD_W_D,
  parameter int STEP_W = STEP_W_D
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vs_in,
  input  logic                   line_tick,
  input  logic [SPC_W-1:0]       cfg_spacing,
  input  logic [FRAC_W-1:0]      cfg_recip,
  input  logic [HOLD_W-1:0]      cfg_hold,
  input  logic [STEP_W-1:0]      cfg_step,
  input  logic [ROW_W-1:0]       cfg_row_first,
  input  logic [ROW_W-1:0]       cfg_row_last,
  input  logic                   cfg_vs_pol,
  input  logic                   cfg_dir_norm,
  input  logic                   col_valid,
  input  logic [COL_W-1:0]       col_idx,
  output logic [ROW_W+COL_W-1:0] rd_addr_a,
  output logic [ROW_W+COL_W-1:0] rd_addr_b,
  input  logic [DW-1:0]          rd_data_a,
  input  logic [DW-1:0]          rd_data_b,
  output logic                   out_valid,
  output logic [DW-1:0]          out_value,
  output logic [COL_W-1:0]       out_col
);
  logic [ROW_W-1:0] row_u;
  logic [SPC_W-1:0] off_u;

  vci_line_track #(
    .ROW_W(ROW_W), .SPC_W(SPC_W), .HOLD_W(HOLD_W), .STEP_W(STEP_W)
  ) u_track (
    .clk(clk), .rst(rst), .vs_in(vs_in), .vs_pol(cfg_vs_pol),
    .line_tick(line_tick), .spacing(cfg_spacing), .hold(cfg_hold),
    .step(cfg_step), .row_first(cfg_row_first), .row_last(cfg_row_last),
    .row_u(row_u), .off_u(off_u)
  );

  vci_row_map #(.ROW_W(ROW_W), .COL_W(COL_W)) u_map (
    .clk(clk), .rst(rst), .row_u(row_u), .row_first(cfg_row_first),
    .row_last(cfg_row_last), .dir_norm(cfg_dir_norm), .col(col_idx),
    .addr_a(rd_addr_a), .addr_b(rd_addr_b)
  );

  vci_lerp #(.DW(DW), .COL_W(COL_W), .SPC_W(SPC_W), .FRAC_W(FRAC_W)) u_lerp (
    .clk(clk), .rst(rst), .off_u(off_u), .recip(cfg_recip),
    .req_v(col_valid), .req_col(col_idx), .da(rd_data_a), .db(rd_data_b),
    .out_valid(out_valid), .out_value(out_value), .out_col(out_col)
  );

  // R11: each request surfaces exactly two cycles later
  p_latency_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(col_valid, 2)));

  // R11: the column tag follows its request
  p_col_tag_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(col_valid, 2)) |-> (out_col == $past(col_idx, 2)));
endmodule

// File: tb/sim_vcorr_interp.sv
module sim_vcorr_interp;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vs_in = 1'b0, line_tick = 1'b0;
  logic [5:0] cfg_spacing = '0;
  logic [6:0] cfg_recip = '0;
  logic [3:0] cfg_hold = '0;
  logic [4:0] cfg_step = '0;
  logic [3:0] cfg_row_first = '0, cfg_row_last = '0;
  logic       cfg_vs_pol = 1'b1, cfg_dir_norm = 1'b1;
  logic       col_valid = 1'b0;
  logic [3:0] col_idx = '0;
  logic [7:0] rd_addr_a, rd_addr_b;
  logic [5:0] rd_data_a, rd_data_b;
  logic       out_valid;
  logic [5:0] out_value;
  logic [3:0] out_col;

  logic [5:0] mem [256];
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vcorr_interp u0 (
    .clk(clk), .rst(rst), .vs_in(vs_in), .line_tick(line_tick),
    .cfg_spacing(cfg_spacing), .cfg_recip(cfg_recip), .cfg_hold(cfg_hold),
    .cfg_step(cfg_step), .cfg_row_first(cfg_row_first), .cfg_row_last(cfg_row_last),
    .cfg_vs_pol(cfg_vs_pol), .cfg_dir_norm(cfg_dir_norm),
    .col_valid(col_valid), .col_idx(col_idx),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .out_valid(out_valid), .out_value(out_value), .out_col(out_col)
  );

  always @(posedge clk) begin
    rd_data_a <= mem[rd_addr_a];
    rd_data_b <= mem[rd_addr_b];
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int used_pos(int line, int hold, int spc, int stp, int span);
    int p, fin;
    if (line <= hold) return 0;
    p = line - hold;
    fin = span * spc;
    if (p >= fin) return fin;
    return (p / stp) * stp;
  endfunction

  function automatic int phys_row(int m, int first, int last, bit norm);
    return norm ? m : first + last - m;
  endfunction

  task automatic pulse_line();
    @(negedge clk); line_tick = 1'b1;
    @(negedge clk); line_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_frame();
    vs_in = ~cfg_vs_pol;
    repeat (2) @(negedge clk);
    vs_in = cfg_vs_pol;
    repeat (2) @(negedge clk);
    vs_in = ~cfg_vs_pol;
    repeat (2) @(negedge clk);
  endtask

  task automatic probe(input int c, input int row, input int a, input string tag, input int line);
    int first, last, rb, pa, pb, f0, f1, d, v;
    bit norm;
    string t;
    first = cfg_row_first; last = cfg_row_last; norm = cfg_dir_norm;
    rb = (row >= last) ? row : row + 1;
    pa = phys_row(row, first, last, norm);
    pb = phys_row(rb, first, last, norm);
    f0 = mem[pa * 16 + c];
    f1 = mem[pb * 16 + c];
    d = f1 - f0;
    v = f0 + ((d * a * int'(cfg_recip) + 2048) >>> 12);
    t = tag;
    if (a == 0) t = {t, " R2"};
    if (v < 0 || v > 63) t = {t, " R10"};
    if (v < 0) v = 0;
    if (v > 63) v = 63;
    @(negedge clk); col_valid = 1'b1; col_idx = 4'(c);
    #1;
    check($sformatf("R9 addr_a line %0d col %0d", line, c), int'(rd_addr_a), pa * 16 + c);
    check($sformatf("R9 addr_b line %0d col %0d", line, c), int'(rd_addr_b), pb * 16 + c);
    @(negedge clk); col_valid = 1'b0;
    check("R11 no early valid", int'(out_valid), 0);
    @(negedge clk);
    check("R11 valid at t+2", int'(out_valid), 1);
    check("R11 column echo", int'(out_col), c);
    check($sformatf("%s value line %0d col %0d", t, line, c), int'(out_value), v);
  endtask

  task automatic run_frame(input int spc, input int rcp, input int hold, input int stp,
                           input int first, input int last, input bit norm, input bit pol,
                           input string tag);
    int s, n, span, lines, pos;
    cfg_spacing = 6'(spc); cfg_recip = 7'(rcp); cfg_hold = 4'(hold); cfg_step = 5'(stp);
    cfg_row_first = 4'(first); cfg_row_last = 4'(last);
    cfg_dir_norm = norm; cfg_vs_pol = pol;
    s = (spc == 0) ? 64 : spc;
    n = (stp == 0) ? 1 : stp;
    span = last - first;
    lines = hold + span * s + 4;
    start_frame();
    for (int line = 0; line <= lines; line++) begin
      string lt;
      if (line > 0) pulse_line();
      lt = tag;
      if (line == 0) lt = {lt, " R3"};
      if (line >= hold + span * s) lt = {lt, " R7"};
      pos = used_pos(line, hold, s, n, span);
      probe(line % 16, first + pos / s, pos % s, lt, line);
      probe((line + 6) % 16, first + pos / s, pos % s, lt, line);
      probe((line + 11) % 16, first + pos / s, pos % s, lt, line);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 6'((i * 29) ^ ((i >> 3) * 7));
    for (int c = 0; c < 16; c++) begin
      mem[4 * 16 + c] = 6'd0;
      mem[5 * 16 + c] = 6'd63;
      mem[6 * 16 + c] = 6'd0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 reset valid", int'(out_valid), 0);
    check("R12 reset value", int'(out_value), 0);

    run_frame(50, 82, 0, 1, 0, 2, 1'b1, 1'b1, "R1 R6");
    run_frame(0, 64, 3, 1, 10, 12, 1'b0, 1'b0, "R1 R4 R6 R8");
    run_frame(40, 102, 2, 3, 3, 5, 1'b1, 1'b1, "R1 R4 R5");
    run_frame(33, 124, 0, 0, 7, 8, 1'b0, 1'b0, "R1 R5 R8");
    run_frame(36, 127, 1, 2, 2, 12, 1'b0, 1'b1, "R1 R5 R8 R10");
    run_frame(48, 85, 15, 31, 5, 5, 1'b1, 1'b0, "R4 R5 R7");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R11 watchdog actual=running expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule